// File: doc/BRIEF.md
# Tagged Many-to-One Message Merge

This block joins the message streams of several independent senders into a single output stream. Every sender writes into a small FIFO of its own. The merge offers one queued message at a time to a single listener. The offered word carries the index of the sender it came from, so the listener can tell the sources apart. Indices are fixed when the design is elaborated: sender lane `i` always carries tag `i`.

The output uses a try-transfer/acknowledge handshake. An offer stays on the output, unchanged, until the listener acknowledges it. Only the acknowledge removes the message from its queue. A round-robin pointer chooses among the non-empty queues, so a busy sender cannot starve a quiet one.

The controller is a two-state machine:

- `ST_IDLE`: no offer is on the output. The transition `pick` fires when at least one queue holds a message. It latches the chosen queue and moves to `ST_OFFER`.
- `ST_OFFER`: the latched queue's head is on the output. The transition `accept` fires on an acknowledge. It dequeues that head, moves the pointer to the next index after the granted queue, and returns to `ST_IDLE`.

Without an acknowledge the machine stays in `ST_OFFER` (`hold`). Without any pending message it stays in `ST_IDLE` (`wait`).

Top module: `tagged_merge`

## Requirements
- R1: After reset `out_valid` is 0 and every bit of `snd_ready` is 1, because all queues are empty.
- R2: `snd_ready[i]` is 1 exactly when queue `i` holds fewer than `DEPTH` messages. A write with `snd_valid[i]` high while `snd_ready[i]` is 1 is stored at the tail of queue `i`.
- R3: A write offered while `snd_ready[i]` is 0 is discarded. The queue contents and the messages that later leave that queue are unaffected.
- R4: While `out_valid` is 1, `out_word[ID_W+DATA_W-1:DATA_W]` holds the sender index and `out_word[DATA_W-1:0]` holds the oldest message of that sender's queue.
- R5: While `out_valid` is 1 and `out_ack` is 0, the same `out_word` with `out_valid` 1 is presented on the next cycle.
- R6: A message leaves its queue only in a cycle where `out_valid` and `out_ack` are both 1. At most one queue is dequeued per cycle. Messages of one sender leave in the order they were written.
- R7: After the queue with index `g` is acknowledged, the next offer comes from the first non-empty queue found when scanning from `g+1` upward, wrapping from `NUM_SRC-1` to 0.
- R8: The first offer after reset comes from the first non-empty queue found when scanning from index 0 upward.
- R9: After an acknowledged cycle, `out_valid` is 0 for one cycle. If `out_valid` is 0 and a queue is non-empty at a clock edge, `out_valid` is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | NUM_SRC | Per-sender write request |
| snd_data | input | NUM_SRC*DATA_W | Per-sender message. Lane `i` is bits `[i*DATA_W +: DATA_W]` |
| snd_ready | output | NUM_SRC | Per-sender "queue not full" |
| out_valid | output | 1 | An offer is on the output |
| out_word | output | ID_W+DATA_W | Sender index (upper bits) followed by the message (lower bits) |
| out_ack | input | 1 | Listener accepts the current offer |

## Verification
The assertions assume that the listener raises `out_ack` only while `out_valid` is high. The design ignores a stray acknowledge, but the dequeue checks are written for a listener that keeps to the handshake, and the stimulus gates every acknowledge with the predicted `out_valid`.

Senders are not held to the same rule. The stimulus deliberately writes into full queues so that the discard behaviour is exercised.

Traffic runs in phases: a filling phase with a slow listener, a light phase, a saturating phase where every sender writes every cycle, and a final drain. Together these reach full queues, wrap-around of the pointer and long acknowledge waits.

// File: rtl/merge_pkg.sv
package merge_pkg;

    // Controller state of the output offer
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } merge_state_t;

endpackage

// File: rtl/src_queue.sv
module src_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              nonempty,
    output logic              not_full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_push, do_pop;

    assign not_full = (count != CNT_W'(DEPTH));
    assign nonempty = (count != '0);
    assign do_push  = push && not_full;
    assign do_pop   = pop && nonempty;
    assign dout     = store[rd_ptr];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= step(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= step(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= din;
        end
    end

    // The controller must never dequeue an empty queue
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty);

    // A full queue stays full unless it is dequeued
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_full && !pop) |=> !not_full);

endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int NUM_SRC = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [IDX_W-1:0]   start,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    localparam int SUM_W = IDX_W + 1;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            logic [SUM_W-1:0] cand;
            cand = SUM_W'(start) + SUM_W'(k);
            if (cand >= SUM_W'(NUM_SRC)) begin
                cand = cand - SUM_W'(NUM_SRC);
            end
            if (!found && req[cand[IDX_W-1:0]]) begin
                found = 1'b1;
                idx   = cand[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/tagged_merge.sv
module tagged_merge
    import merge_pkg::*;
#(
    parameter  int NUM_SRC = 4,
    parameter  int DATA_W  = 8,
    parameter  int DEPTH   = 4,
    localparam int ID_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        snd_valid,
    input  logic [NUM_SRC*DATA_W-1:0] snd_data,
    output logic [NUM_SRC-1:0]        snd_ready,
    output logic                      out_valid,
    output logic [ID_W+DATA_W-1:0]    out_word,
    input  logic                      out_ack
);
    merge_state_t      state_q, state_d;
    logic [ID_W-1:0]   grant_q, grant_d;
    logic [ID_W-1:0]   ptr_q, ptr_d;
    logic [NUM_SRC-1:0] nonempty;
    logic [NUM_SRC-1:0] pop_vec;
    logic [DATA_W-1:0] head [NUM_SRC];
    logic              pick_found;
    logic [ID_W-1:0]   pick_idx;

    // One private queue per sender
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
        src_queue #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_queue (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (snd_valid[i]),
            .din      (snd_data[i*DATA_W +: DATA_W]),
            .pop      (pop_vec[i]),
            .dout     (head[i]),
            .nonempty (nonempty[i]),
            .not_full (snd_ready[i])
        );
    end

    rr_picker #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (ID_W)
    ) u_pick (
        .req   (nonempty),
        .start (ptr_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
            ptr_q   <= ptr_d;
        end
    end

    // Transitions: wait, pick, hold, accept
    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_found) begin
                    state_d = ST_OFFER;
                    grant_d = pick_idx;
                end
            end
            ST_OFFER: begin
                if (out_ack) begin
                    state_d = ST_IDLE;
                    if (grant_q == ID_W'(NUM_SRC - 1)) begin
                        ptr_d = '0;
                    end else begin
                        ptr_d = grant_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        out_valid = (state_q == ST_OFFER);
        out_word  = {grant_q, head[grant_q]};
        for (int i = 0; i < NUM_SRC; i++) begin
            pop_vec[i] = out_valid && out_ack && (grant_q == ID_W'(i));
        end
    end

    assert_offer_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ack) |=> (out_valid && $stable(out_word)));

    assert_gap_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ack) |=> !out_valid);

    assert_offer_from_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> nonempty[grant_q]);

    assert_single_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_vec));

endmodule

// File: tb/tagged_merge_tb.sv
module tagged_merge_tb;
    localparam int NS    = 4;
    localparam int DW    = 8;
    localparam int DEP   = 4;
    localparam int IW    = 2;
    localparam int NCYC  = 1600;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NS-1:0]     snd_valid;
    logic [NS*DW-1:0]  snd_data;
    logic [NS-1:0]     snd_ready;
    logic              out_valid;
    logic [IW+DW-1:0]  out_word;
    logic              out_ack;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tagged_merge #(.NUM_SRC(NS), .DATA_W(DW), .DEPTH(DEP)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .snd_valid (snd_valid),
        .snd_data  (snd_data),
        .snd_ready (snd_ready),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_ack   (out_ack)
    );

    // Behavioural reference
    logic [DW-1:0] mq [NS][$];
    bit m_offer;
    int m_grant;
    int m_ptr;
    bit m_held;
    bit m_first;
    bit m_full_hit;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        logic [NS-1:0]    exp_rdy;
        logic [IW+DW-1:0] exp_word;
        string tag;
        for (int i = 0; i < NS; i++) exp_rdy[i] = (mq[i].size() < DEP);
        chk(out_valid == m_offer, "R9 valid", 32'(out_valid), 32'(m_offer));
        chk(snd_ready == exp_rdy, m_full_hit ? "R3 ready" : "R2 ready",
            32'(snd_ready), 32'(exp_rdy));
        if (m_offer) begin
            exp_word = {IW'(m_grant), mq[m_grant][0]};
            tag = m_first ? "R8 word" : (m_held ? "R5 word" : "R4 R6 R7 word");
            chk(out_word == exp_word, tag, 32'(out_word), 32'(exp_word));
        end
    endtask

    task automatic advance(input logic [NS-1:0] v, input logic [NS*DW-1:0] d, input bit ack);
        int pre [NS];
        bit was_offer;
        for (int i = 0; i < NS; i++) pre[i] = mq[i].size();
        was_offer  = m_offer;
        m_held     = 1'b0;
        m_full_hit = 1'b0;
        if (m_offer) begin
            if (m_first && ack) m_first = 1'b0;
            if (ack) begin
                void'(mq[m_grant].pop_front());
                m_ptr   = (m_grant + 1) % NS;
                m_offer = 1'b0;
            end else begin
                m_held = 1'b1;
            end
        end else begin
            for (int k = 0; k < NS; k++) begin
                int c;
                c = (m_ptr + k) % NS;
                if (!m_offer && pre[c] > 0) begin
                    m_offer = 1'b1;
                    m_grant = c;
                end
            end
        end
        if (was_offer && !m_offer) m_first = 1'b0;
        for (int i = 0; i < NS; i++) begin
            if (v[i]) begin
                if (pre[i] < DEP) mq[i].push_back(d[i*DW +: DW]);
                else m_full_hit = 1'b1;
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        snd_valid = '0;
        snd_data  = '0;
        out_ack   = 1'b0;
        m_offer = 0; m_grant = 0; m_ptr = 0; m_held = 0; m_first = 1; m_full_hit = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid", 32'(out_valid), 0);
        chk(snd_ready == '1, "R1 ready", 32'(snd_ready), 32'hF);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            logic [NS-1:0]    v;
            logic [NS*DW-1:0] d;
            bit               a;
            int               wp, ap;
            if (cyc > 0) @(negedge clk);
            compare();
            if (cyc == 0)        begin wp = 100; ap = 0;   end
            else if (cyc < 400)  begin wp = 80;  ap = 25;  end
            else if (cyc < 800)  begin wp = 20;  ap = 90;  end
            else if (cyc < 1200) begin wp = 100; ap = 100; end
            else if (cyc < 1400) begin wp = 50;  ap = 60;  end
            else                 begin wp = 0;   ap = 100; end
            for (int i = 0; i < NS; i++) begin
                v[i] = ($urandom_range(99) < wp);
                d[i*DW +: DW] = DW'($urandom);
            end
            a = m_offer && ($urandom_range(99) < ap);
            snd_valid = v;
            snd_data  = d;
            out_ack   = a;
            advance(v, d, a);
        end
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule